// File: doc/BRIEF.md
# Interrupt Source Event-State Controller

This block keeps a two-bit event state for each of a bank of interrupt sources and uses it to merge hardware triggers. Each source can then have at most one notification outstanding toward a downstream event queue. Bit P (weight 2) marks a source that has been forwarded and is waiting for end-of-interrupt. Bit Q (weight 1) records that another trigger arrived while P was already set. When a source is forwarded, the block emits a one-cycle notify pulse that carries the source index.

Software controls the sources through a load/store register port. Each source owns one page, and bits [11:8] of the page offset select the operation. Every load is an atomic read-modify-write that returns the state from before the operation, one cycle after the load is accepted. The operations are end-of-interrupt, a plain state read, and a forced write of one of the four state values. A store can also perform end-of-interrupt, but only for sources whose store-EOI flag is set.

Sources can be edge or level sensitive, chosen per source by a parameter. On a level source, end-of-interrupt re-fires the source when its input is still asserted.

Top module: `pq_event_ctrl`

## Requirements
- R1: After reset every source state is 00, and neither `rsp_vld_o` nor `notify_vld_o` is asserted.
- R2: A load with offset nibble 0x8 returns the state as {P,Q} in `rsp_data_o[1:0]` and leaves the state unchanged. For every load, `rsp_vld_o` is high exactly in the cycle after the load is accepted and never otherwise.
- R3: Every load returns the state held before its own update; the read and the update are one atomic step.
- R4: Loads with offset nibbles 0xC, 0xD, 0xE and 0xF force the state to 00, 01, 10 and 11 respectively.
- R5: A trigger on an edge source moves 00 to 10 and forwards it, moves 10 and 11 to 11, and leaves 01 (masked) at 01. Only the move from 00 forwards a notification.
- R6: A load with offset nibble 0x0 performs end-of-interrupt on an edge source: 10 goes to 00, 11 goes to 10 with a new notification, and 00 and 01 are unchanged.
- R7: A store with offset nibble 0x4 performs end-of-interrupt only when the source's store-EOI flag is set; otherwise it has no effect. Stores at any other offset have no effect. Loads at offset nibbles other than 0x0, 0x8 and 0xC to 0xF behave as plain reads.
- R8: Level sources trigger in every cycle their input is high. Their end-of-interrupt clears a non-masked state to 00 regardless of Q, then re-fires immediately if the input is still high.
- R9: When an access and a trigger hit the same source in the same cycle, the access is applied first and the trigger is evaluated against the result.
- R10: Each forward yields a notify pulse in the cycle after the forwarding edge. Only one pulse is issued per cycle, with the lowest pending index first. A source forwarded again before its pending pulse is issued yields a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NUM_SRC | Per-source trigger event (edge sources) or level (level sources) |
| req_i | input | 1 | Register access valid |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_addr_i | input | SRC_W+PAGE_SHIFT | Source index in the upper bits; operation in offset bits [11:8] |
| rsp_vld_o | output | 1 | Load data valid |
| rsp_data_o | output | 2 | Previous {P,Q} of the loaded source |
| notify_vld_o | output | 1 | Notify pulse |
| notify_idx_o | output | SRC_W | Index of the notified source |

## Verification
The hardest situations to reach are those where several effects land on one source in the same cycle. Examples are a forced 00 together with a trigger, an end-of-interrupt on 11 together with a fresh trigger, and a level source whose input is still high at its end-of-interrupt. The stimulus issues each access with chosen trigger vectors in that same cycle. A reference model is updated per cycle, so merged, re-fired and simultaneous forwards are checked in issue order, lowest index first.

// File: rtl/pq_esc_pkg.sv
package pq_esc_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_READ = 2'd1,
        OP_EOI  = 2'd2,
        OP_SET  = 2'd3
    } op_e;

    typedef struct packed {
        op_e        op;
        logic [1:0] val;
    } acc_t;

    localparam logic [1:0] PQ_IDLE = 2'b00;
    localparam logic [1:0] PQ_OFF  = 2'b01;
    localparam logic [1:0] PQ_PEND = 2'b10;
    localparam logic [1:0] PQ_BOTH = 2'b11;

    localparam logic [3:0] NIB_EOI_LD = 4'h0;
    localparam logic [3:0] NIB_EOI_ST = 4'h4;
    localparam logic [3:0] NIB_READ   = 4'h8;

endpackage

// File: rtl/pq_decode.sv
module pq_decode
    import pq_esc_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 SRC_W      = 3,
    parameter int                 PAGE_SHIFT = 12,
    parameter logic [NUM_SRC-1:0] STEOI_MASK = '0,
    localparam int                ADDR_W     = SRC_W + PAGE_SHIFT
) (
    input  logic               req_i,
    input  logic               req_we_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    output acc_t               acc_o,
    output logic [NUM_SRC-1:0] hit_o,
    output logic               load_o,
    output logic               idx_ok_o,
    output logic [SRC_W-1:0]   idx_o
);

    logic [3:0] nib;

    always_comb begin
        nib      = req_addr_i[11:8];
        idx_o    = req_addr_i[PAGE_SHIFT +: SRC_W];
        idx_ok_o = ({1'b0, idx_o} < (SRC_W+1)'(NUM_SRC));
        acc_o    = '{op: OP_NONE, val: 2'b00};
        hit_o    = '0;
        load_o   = req_i && !req_we_i;
        if (req_i && idx_ok_o) begin
            if (!req_we_i) begin
                if (nib == NIB_EOI_LD) begin
                    acc_o.op = OP_EOI;
                end else if (nib[3:2] == 2'b11) begin
                    acc_o.op  = OP_SET;
                    acc_o.val = nib[1:0];
                end else begin
                    acc_o.op = OP_READ;
                end
            end else if (nib == NIB_EOI_ST && STEOI_MASK[idx_o]) begin
                acc_o.op = OP_EOI;
            end
            if (acc_o.op != OP_NONE) begin
                hit_o[idx_o] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pq_cell.sv
module pq_cell
    import pq_esc_pkg::*;
#(
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic [1:0] pq_q,
    input  logic       hit_i,
    input  acc_t       acc_i,
    input  logic       trig_i,
    output logic [1:0] pq_d,
    output logic       fwd_o
);

    logic [1:0] mid;
    logic       eoi_fwd;
    logic       trig_fwd;

    always_comb begin
        // access stage
        mid     = pq_q;
        eoi_fwd = 1'b0;
        if (hit_i) begin
            case (acc_i.op)
                OP_EOI: begin
                    if (IS_LEVEL) begin
                        if (pq_q != PQ_OFF) mid = PQ_IDLE;
                    end else if (pq_q == PQ_PEND) begin
                        mid = PQ_IDLE;
                    end else if (pq_q == PQ_BOTH) begin
                        mid     = PQ_PEND;
                        eoi_fwd = 1'b1;
                    end
                end
                OP_SET:  mid = acc_i.val;
                default: ;
            endcase
        end
        // trigger stage, against the post-access state
        pq_d     = mid;
        trig_fwd = 1'b0;
        if (trig_i) begin
            case (mid)
                PQ_IDLE: begin
                    pq_d     = PQ_PEND;
                    trig_fwd = 1'b1;
                end
                PQ_PEND, PQ_BOTH: pq_d = PQ_BOTH;
                default: ;
            endcase
        end
        fwd_o = eoi_fwd || trig_fwd;
    end

endmodule

// File: rtl/notify_arb.sv
module notify_arb #(
    parameter int N = 8,
    parameter int W = 3
) (
    input  logic [N-1:0] req_i,
    output logic         vld_o,
    output logic [W-1:0] idx_o,
    output logic [N-1:0] grant_o
);

    always_comb begin
        vld_o   = 1'b0;
        idx_o   = '0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !vld_o) begin
                vld_o      = 1'b1;
                idx_o      = W'(i);
                grant_o[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pq_event_ctrl.sv
module pq_event_ctrl
    import pq_esc_pkg::*;
#(
    parameter int                 NUM_SRC    = 8,
    parameter int                 PAGE_SHIFT = 12,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'('hC0),
    parameter logic [NUM_SRC-1:0] STEOI_MASK = NUM_SRC'('h0F),
    localparam int                SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int                ADDR_W     = SRC_W + PAGE_SHIFT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               req_i,
    input  logic               req_we_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    output logic               rsp_vld_o,
    output logic [1:0]         rsp_data_o,
    output logic               notify_vld_o,
    output logic [SRC_W-1:0]   notify_idx_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0][1:0] pq;
        logic [NUM_SRC-1:0]      pend;
        logic                    rsp_vld;
        logic [1:0]              rsp_data;
    } state_t;

    state_t st_d, st_q;

    acc_t                    acc;
    logic [NUM_SRC-1:0]      hit;
    logic                    load;
    logic                    idx_ok;
    logic [SRC_W-1:0]        idx;
    logic [NUM_SRC-1:0][1:0] pq_nx;
    logic [NUM_SRC-1:0]      fwd;
    logic [NUM_SRC-1:0]      grant;
    logic [NUM_SRC-1:0][1:0] pq_q;

    assign pq_q = st_q.pq;

    pq_decode #(
        .NUM_SRC   (NUM_SRC),
        .SRC_W     (SRC_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .STEOI_MASK(STEOI_MASK)
    ) u_dec (
        .req_i     (req_i),
        .req_we_i  (req_we_i),
        .req_addr_i(req_addr_i),
        .acc_o     (acc),
        .hit_o     (hit),
        .load_o    (load),
        .idx_ok_o  (idx_ok),
        .idx_o     (idx)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        pq_cell #(
            .IS_LEVEL(LEVEL_MASK[g])
        ) u_cell (
            .pq_q  (st_q.pq[g]),
            .hit_i (hit[g]),
            .acc_i (acc),
            .trig_i(src_i[g]),
            .pq_d  (pq_nx[g]),
            .fwd_o (fwd[g])
        );
    end

    notify_arb #(
        .N(NUM_SRC),
        .W(SRC_W)
    ) u_arb (
        .req_i  (st_q.pend),
        .vld_o  (notify_vld_o),
        .idx_o  (notify_idx_o),
        .grant_o(grant)
    );

    always_comb begin
        st_d          = st_q;
        st_d.pq       = pq_nx;
        st_d.pend     = (st_q.pend & ~grant) | fwd;
        st_d.rsp_vld  = load;
        st_d.rsp_data = (load && idx_ok) ? st_q.pq[idx] : 2'b00;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_vld_o  = st_q.rsp_vld;
    assign rsp_data_o = st_q.rsp_data;

endmodule

// File: rtl/pq_event_ctrl_chk.sv
module pq_event_ctrl_chk #(
    parameter int NUM_SRC    = 8,
    parameter int PAGE_SHIFT = 12,
    parameter int SRC_W      = 3,
    localparam int ADDR_W    = SRC_W + PAGE_SHIFT
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_SRC-1:0]      src_i,
    input logic                    req_i,
    input logic                    req_we_i,
    input logic [ADDR_W-1:0]       req_addr_i,
    input logic                    rsp_vld_o,
    input logic [1:0]              rsp_data_o,
    input logic [NUM_SRC-1:0][1:0] pq_q
);

    logic [SRC_W-1:0] a_idx;
    logic [3:0]       a_nib;
    logic             a_load;
    logic             a_ok;
    logic [1:0]       a_old;

    always_comb begin
        a_idx  = req_addr_i[PAGE_SHIFT +: SRC_W];
        a_nib  = req_addr_i[11:8];
        a_load = req_i && !req_we_i;
        a_ok   = ({1'b0, a_idx} < (SRC_W+1)'(NUM_SRC));
        a_old  = a_ok ? pq_q[a_idx] : 2'b00;
    end

    AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        a_load |=> rsp_vld_o); // R2
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !a_load |=> !rsp_vld_o); // R2
    AST_RSP_OLD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        a_load |=> rsp_data_o == $past(a_old)); // R3

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        logic hit_i;
        assign hit_i = req_i && a_idx == SRC_W'(i);

        AST_TRIG_SETS_Q: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_i && src_i[i] && pq_q[i][1] |=> pq_q[i] == 2'b11); // R5
        AST_MASKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !hit_i && pq_q[i] == 2'b01 |=> pq_q[i] == 2'b01); // R5
        AST_FORCE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i && !req_we_i && a_nib[3:2] == 2'b11 && !src_i[i]
            |=> pq_q[i] == $past(req_addr_i[9:8])); // R4
        AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
            hit_i && !req_we_i && a_nib == 4'h8 && !src_i[i]
            |=> pq_q[i] == $past(pq_q[i])); // R2
    end

endmodule

bind pq_event_ctrl pq_event_ctrl_chk #(
    .NUM_SRC   (NUM_SRC),
    .PAGE_SHIFT(PAGE_SHIFT),
    .SRC_W     (SRC_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_i     (src_i),
    .req_i     (req_i),
    .req_we_i  (req_we_i),
    .req_addr_i(req_addr_i),
    .rsp_vld_o (rsp_vld_o),
    .rsp_data_o(rsp_data_o),
    .pq_q      (pq_q)
);

// File: tb/pq_event_ctrl_tb.sv
module pq_event_ctrl_tb;

    localparam int         N     = 8;
    localparam logic [7:0] LVL_M = 8'hC0;
    localparam logic [7:0] STE_M = 8'h0F;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_i = '0;
    logic         req_i = 1'b0;
    logic         req_we_i = 1'b0;
    logic [14:0]  req_addr_i = '0;
    logic         rsp_vld_o;
    logic [1:0]   rsp_data_o;
    logic         notify_vld_o;
    logic [2:0]   notify_idx_o;

    always #10 clk = ~clk;

    pq_event_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .req_i       (req_i),
        .req_we_i    (req_we_i),
        .req_addr_i  (req_addr_i),
        .rsp_vld_o   (rsp_vld_o),
        .rsp_data_o  (rsp_data_o),
        .notify_vld_o(notify_vld_o),
        .notify_idx_o(notify_idx_o)
    );

    typedef struct {
        logic [1:0] val;
        int         due;
        string      tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [1:0] m_pq[N];
    logic [N-1:0] m_pend = '0;
    logic [N-1:0] lvl = '0;
    int ncyc = 0;
    int checks = 0;
    int errors = 0;

    // driver: one cycle of stimulus, model updated from the requirements
    task automatic cyc(input bit acc, input bit we, input int s,
                       input logic [3:0] nib, input logic [N-1:0] trg,
                       input string tag);
        logic [N-1:0] src;
        @(posedge clk);
        #10;
        src        = trg | lvl;
        req_i      = acc;
        req_we_i   = we;
        req_addr_i = {3'(s), nib, 8'h00};
        src_i      = src;
        if (acc && !we) exp_q.push_back('{val: (s < N) ? m_pq[s] : 2'b00, due: ncyc + 1, tag: tag});
        for (int k = 0; k < N; k++) begin
            logic [1:0] mid;
            bit h, eoi, f;
            h   = acc && (s == k);
            eoi = h && ((!we && nib == 4'h0) || (we && nib == 4'h4 && STE_M[k]));
            mid = m_pq[k];
            f   = 1'b0;
            if (eoi) begin
                if (LVL_M[k]) begin
                    if (mid != 2'b01) mid = 2'b00;
                end else if (mid == 2'b10) mid = 2'b00;
                else if (mid == 2'b11) begin mid = 2'b10; f = 1'b1; end
            end else if (h && !we && nib[3:2] == 2'b11) begin
                mid = nib[1:0];
            end
            if (src[k]) begin
                if (mid == 2'b00) begin mid = 2'b10; f = 1'b1; end
                else if (mid[1]) mid = 2'b11;
            end
            m_pq[k] = mid;
            if (f) m_pend[k] = 1'b1;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 4'h0, '0, "");
    endtask

    task automatic ld(input int s, input logic [3:0] nib, input string tag);
        cyc(1, 0, s, nib, '0, tag);
    endtask

    // monitor: pops the scoreboard as results appear
    initial begin
        forever begin
            @(posedge clk);
            #5;
            ncyc++;
            if (rst_n) begin
                if (exp_q.size() > 0 && exp_q[0].due == ncyc) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    checks++;
                    if (!rsp_vld_o || rsp_data_o !== e.val) begin
                        errors++;
                        $display("FAIL %s: rsp vld=%0b data=%0b expected vld=1 data=%0b",
                                 e.tag, rsp_vld_o, rsp_data_o, e.val);
                    end
                end else if (rsp_vld_o) begin
                    checks++;
                    errors++;
                    $display("FAIL R2: unexpected rsp data=%0b expected none", rsp_data_o);
                end
                if (m_pend != '0) begin
                    int lo;
                    lo = 0;
                    for (int k = N - 1; k >= 0; k--) if (m_pend[k]) lo = k;
                    m_pend[lo] = 1'b0;
                    checks++;
                    if (!notify_vld_o || notify_idx_o !== 3'(lo)) begin
                        errors++;
                        $display("FAIL R10: notify vld=%0b idx=%0d expected vld=1 idx=%0d",
                                 notify_vld_o, notify_idx_o, lo);
                    end
                end else if (notify_vld_o) begin
                    checks++;
                    errors++;
                    $display("FAIL R10: unexpected notify idx=%0d expected none", notify_idx_o);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < N; k++) m_pq[k] = 2'b00;
        repeat (3) @(posedge clk);
        #10;
        rst_n = 1'b1;
        #2;
        checks++;
        if (rsp_vld_o !== 1'b0 || notify_vld_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_vld=%0b notify_vld=%0b expected 0 0", rsp_vld_o, notify_vld_o);
        end
        for (int k = 0; k < N; k++) ld(k, 4'h8, "R1");
        // edge source 2: trigger, coalesce, EOI sequence
        ld(2, 4'h8, "R2");
        cyc(0, 0, 0, 4'h0, 8'h04, "");
        ld(2, 4'h8, "R5");
        cyc(0, 0, 0, 4'h0, 8'h04, "");
        cyc(0, 0, 0, 4'h0, 8'h04, "");
        ld(2, 4'h8, "R5");
        ld(2, 4'h0, "R6");
        ld(2, 4'h0, "R6");
        ld(2, 4'h0, "R6");
        ld(2, 4'h8, "R6");
        // masked source 3 and forced values
        ld(3, 4'hD, "R4");
        cyc(0, 0, 0, 4'h0, 8'h08, "");
        ld(3, 4'h8, "R5");
        ld(3, 4'h0, "R6");
        ld(3, 4'hE, "R4");
        ld(3, 4'hF, "R3");
        ld(3, 4'hC, "R3");
        ld(3, 4'h8, "R4");
        // store EOI and ignored stores
        cyc(0, 0, 0, 4'h0, 8'h22, "");
        cyc(1, 1, 1, 4'h4, '0, "");
        ld(1, 4'h8, "R7");
        cyc(1, 1, 5, 4'h4, '0, "");
        ld(5, 4'h8, "R7");
        cyc(1, 1, 5, 4'hC, '0, "");
        ld(5, 4'h4, "R7");
        ld(5, 4'h0, "R6");
        // simultaneous triggers
        cyc(0, 0, 0, 4'h0, 8'h31, "");
        cyc(0, 0, 0, 4'h0, 8'h01, "");
        idle(4);
        ld(4, 4'h8, "R10");
        // level source 6
        lvl[6] = 1'b1;
        idle(2);
        ld(6, 4'h8, "R8");
        ld(6, 4'h0, "R8");
        ld(6, 4'h8, "R8");
        lvl[6] = 1'b0;
        idle(1);
        ld(6, 4'h0, "R8");
        ld(6, 4'h8, "R8");
        // same-cycle access and trigger
        ld(2, 4'hF, "R4");
        cyc(1, 0, 2, 4'hC, 8'h04, "R9");
        cyc(0, 0, 0, 4'h0, 8'h04, "");
        cyc(1, 0, 2, 4'h0, 8'h04, "R9");
        ld(2, 4'h8, "R9");
        idle(12);
        checks++;
        if (exp_q.size() != 0 || m_pend != '0) begin
            errors++;
            $display("FAIL R10: leftover rsp=%0d notify=%b expected 0 and 0", exp_q.size(), m_pend);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule